// File: doc/BRIEF.md
# Maskable Interrupt Collector with Standby Wake

This block gathers six interrupt sources into one request line for a processor core. Four come from external pins. Each pin is resynchronised and then edge-detected, and a build-time parameter fixes the active edge of each pin. The other two are single-cycle pulses from an on-chip prescaler and an on-chip timer. Every source sets a sticky flag. Per-source masks and a global enable then decide whether the flags reach the core.

Flags are set whether or not they are masked. Reading a flag register returns its contents and clears it in the same access. A small power-state machine has two states:

- `ST_RUN`: the core is executing.
- `ST_STANDBY`: the core is halted.

There are two transitions:

- The *halt transition* from `ST_RUN` to `ST_STANDBY` is taken when `halt_i` is high.
- The *wake transition* from `ST_STANDBY` back to `ST_RUN` is taken in any cycle where the gated request line is high. `wake_o` flags that cycle.

Top module: `irq_hub`

## Requirements
- R1: A pin whose bit in `EDGE_RISE` is 1 (default: pins 0 and 2) sets its external flag on a 0-to-1 transition only. The flag is readable after the third rising clock edge following the pin change, and a 1-to-0 transition sets nothing.
- R2: A pin whose bit in `EDGE_RISE` is 0 (default: pins 1 and 3) sets its external flag on a 1-to-0 transition only, with the same three-edge latency. A 0-to-1 transition sets nothing.
- R3: A high cycle on `prs_tick_i` sets internal flag bit 0, and a high cycle on `tmr_tick_i` sets internal flag bit 1, both at the next clock edge.
- R4: Flags are set regardless of the mask and global enable values. Writing a mask register never changes the flags.
- R5: Register map on `addr_i`:
  - Address 0 holds the external flags, one bit per pin.
  - Address 1 holds the internal flags in bits 1:0.
  - Address 2 holds the external mask, one bit per pin.
  - Address 3 holds the timer/prescaler masks in bits 1:0 and the global enable in bit 3.

  `rdata_o` shows the addressed register combinationally. Writes to addresses 0 and 1 have no effect.
- R6: A cycle with `rd_en_i` high at address 0 or 1 clears that flag register at the clock edge and leaves the other flag register unchanged.
- R7: A source event arriving in the same cycle as a clearing read of its register stays set after that edge.
- R8: `irq_o` is high exactly when the global enable is 1 and at least one flag is set whose mask bit is 1.
- R9: After reset, all flags, masks and the global enable are 0, `irq_o`, `wake_o` and `standby_o` are 0, and the state is `ST_RUN`.
- R10: In `ST_RUN`, `halt_i` high moves the state to `ST_STANDBY` at the next edge, and `standby_o` is high while in `ST_STANDBY`.
- R11: In `ST_STANDBY`, `wake_o` is high in exactly the cycles where `irq_o` is high, and the state returns to `ST_RUN` at the following edge. A masked pending flag does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_EXT | External interrupt pins, asynchronous |
| prs_tick_i | input | 1 | Prescaler request pulse |
| tmr_tick_i | input | 1 | Timer request pulse |
| rd_en_i | input | 1 | Read strobe; clears an addressed flag register |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | N_EXT | Write data |
| rdata_o | output | N_EXT | Contents of the addressed register |
| halt_i | input | 1 | Core requests standby |
| irq_o | output | 1 | Gated interrupt request to the core |
| wake_o | output | 1 | High in the cycle standby is cancelled |
| standby_o | output | 1 | High while in standby |

## Verification
The embedded properties cover the following on every cycle:
- A detected edge lasts a single cycle.
- A source event always lands in its flag, including when a clear occurs in the same cycle.
- A clear empties the bits that had no new event.
- `halt_i` and the wake transition move the state machine as stated.
- The block never leaves standby without a request.

Only the bench scenarios can show the following:
- Edge polarity per pin and the three-edge latency.
- The full mask and global-enable sweep against a fixed flag pattern.
- Read-clear data returned before the clear.
- That a masked flag leaves the block in standby until its mask is opened.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_INT = 2;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADR_EXT_FLAG = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_INT_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_EXT_MASK = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL     = 2'd3;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_STANDBY = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int   STAGES = 2,
    parameter logic RISE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic edge_o
);
    localparam logic IDLE = ~RISE;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {STAGES{IDLE}};
            prev_q <= IDLE;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = sync_q[STAGES-1] & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sync_q[STAGES-1] & prev_q;
        end
    endgenerate

    // R1 / R2: a detected edge never lasts two cycles
    a_r1_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (clr_i ? '0 : flags_q) | set_i;
        end
    end

    assign flags_o = flags_q;

    // R7: an event is never lost, even with a clear in the same cycle
    a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R6: a clear empties every bit that had no new event
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((flags_q & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_wake_fsm.sv
module irq_wake_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic req_i,
    output logic wake_o,
    output logic standby_o
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (halt_i) state_d = ST_STANDBY;
            ST_STANDBY: if (req_i)  state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_comb begin
        wake_o    = 1'b0;
        standby_o = 1'b0;
        unique case (state_q)
            ST_RUN:     ;
            ST_STANDBY: begin
                standby_o = 1'b1;
                wake_o    = req_i;
            end
            default:    ;
        endcase
    end

    a_r10_halt_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && halt_i) |=> (state_q == ST_STANDBY));

    a_r11_wake_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && req_i) |=> (state_q == ST_RUN));

    a_r11_no_req_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !req_i) |=> (state_q == ST_STANDBY));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_pkg::*;
#(
    parameter int               N_EXT     = 4,
    parameter logic [N_EXT-1:0] EDGE_RISE = 4'b0101,
    parameter int               SYNC_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin_i,
    input  logic             prs_tick_i,
    input  logic             tmr_tick_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [N_EXT-1:0] wdata_i,
    output logic [N_EXT-1:0] rdata_o,
    input  logic             halt_i,
    output logic             irq_o,
    output logic             wake_o,
    output logic             standby_o
);
    localparam int GEN_BIT = N_EXT - 1;

    logic [N_EXT-1:0]   ext_edge, ext_flags, ext_mask_q;
    logic [NUM_INT-1:0] int_set, int_flags, int_mask_q;
    logic               gen_en_q;
    logic               clr_ext, clr_int;
    logic [N_EXT-1:0]   ctrl_view, int_view;

    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_pin
            irq_edge_sync #(.STAGES(SYNC_LEN), .RISE(EDGE_RISE[gi])) u_sync (
                .clk(clk), .rst_n(rst_n), .pin_i(pin_i[gi]), .edge_o(ext_edge[gi])
            );
        end
    endgenerate

    assign int_set = {tmr_tick_i, prs_tick_i};
    assign clr_ext = rd_en_i && (addr_i == ADR_EXT_FLAG);
    assign clr_int = rd_en_i && (addr_i == ADR_INT_FLAG);

    irq_flag_bank #(.W(N_EXT)) u_ext_flags (
        .clk(clk), .rst_n(rst_n), .set_i(ext_edge), .clr_i(clr_ext), .flags_o(ext_flags)
    );

    irq_flag_bank #(.W(NUM_INT)) u_int_flags (
        .clk(clk), .rst_n(rst_n), .set_i(int_set), .clr_i(clr_int), .flags_o(int_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_mask_q <= '0;
            int_mask_q <= '0;
            gen_en_q   <= 1'b0;
        end else if (wr_en_i) begin
            if (addr_i == ADR_EXT_MASK) ext_mask_q <= wdata_i;
            if (addr_i == ADR_CTRL) begin
                int_mask_q <= wdata_i[NUM_INT-1:0];
                gen_en_q   <= wdata_i[GEN_BIT];
            end
        end
    end

    always_comb begin
        int_view                = '0;
        int_view[NUM_INT-1:0]   = int_flags;
        ctrl_view               = '0;
        ctrl_view[NUM_INT-1:0]  = int_mask_q;
        ctrl_view[GEN_BIT]      = gen_en_q;
        unique case (addr_i)
            ADR_EXT_FLAG: rdata_o = ext_flags;
            ADR_INT_FLAG: rdata_o = int_view;
            ADR_EXT_MASK: rdata_o = ext_mask_q;
            ADR_CTRL:     rdata_o = ctrl_view;
            default:      rdata_o = '0;
        endcase
    end

    assign irq_o = gen_en_q && (((ext_flags & ext_mask_q) != '0) ||
                                ((int_flags & int_mask_q) != '0));

    irq_wake_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .req_i(irq_o),
        .wake_o(wake_o), .standby_o(standby_o)
    );

    // R4: a mask write never disturbs flags when no read or event occurs
    a_r4_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !rd_en_i && ext_edge == '0) |=> $stable(ext_flags));

    // R11: leaving standby always comes with a request
    a_r11_wake_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby_o) |-> $past(irq_o));
endmodule

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] RISE = 4'b0101;
    localparam logic [3:0] IDLE = ~RISE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = IDLE;
    logic       prs = 1'b0, tmr = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [3:0] wdata = 4'd0;
    logic [3:0] rdata;
    logic       halt = 1'b0;
    logic       irq, wake, standby;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub #(.N_EXT(4), .EDGE_RISE(RISE)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .prs_tick_i(prs), .tmr_tick_i(tmr),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .halt_i(halt), .irq_o(irq), .wake_o(wake), .standby_o(standby)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [3:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] v;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);

        // R9: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            check("R9 reg", int'(v), 0);
        end
        check("R9 irq", int'(irq), 0);
        check("R9 wake", int'(wake), 0);
        check("R9 standby", int'(standby), 0);

        // R1 / R2: each pin, active edge then inactive edge
        for (int i = 0; i < 4; i++) begin
            string tag;
            tag = RISE[i] ? "R1" : "R2";
            rd(2'd0, v);
            pin[i] = ~IDLE[i];
            cycles(2);
            peek(2'd0, v);
            check({tag, " latency"}, int'(v), 0);
            cycles(1);
            peek(2'd0, v);
            check({tag, " active edge"}, int'(v), 1 << i);
            rd(2'd0, v);
            check({tag, " R6 read value"}, int'(v), 1 << i);
            peek(2'd0, v);
            check("R6 cleared", int'(v), 0);
            pin[i] = IDLE[i];
            cycles(4);
            peek(2'd0, v);
            check({tag, " inactive edge"}, int'(v), 0);
        end

        // R3: internal ticks
        prs = 1'b1; cycles(1); prs = 1'b0;
        peek(2'd1, v);
        check("R3 prescaler", int'(v), 1);
        tmr = 1'b1; cycles(1); tmr = 1'b0;
        peek(2'd1, v);
        check("R3 timer", int'(v), 3);

        // R6: clearing internal flags leaves external flags; R7 collision
        pin[0] = 1'b1; cycles(4); pin[0] = 1'b0; cycles(4);
        addr = 2'd1; rd_en = 1'b1; prs = 1'b1;
        #1 check("R7 read value", int'(rdata), 3);
        @(negedge clk);
        rd_en = 1'b0; prs = 1'b0;
        peek(2'd1, v);
        check("R7 event kept", int'(v), 1);
        peek(2'd0, v);
        check("R6 other reg kept", int'(v), 1);

        // R5: writes to flag registers are ignored
        wr(2'd0, 4'hF);
        wr(2'd1, 4'hF);
        peek(2'd0, v);
        check("R5 ext flag write", int'(v), 1);
        peek(2'd1, v);
        check("R5 int flag write", int'(v), 1);

        // Build flag pattern: ext pins 0,2 and timer -> combined {tmr,prs,ext}=6'b100101
        rd(2'd1, v);
        rd(2'd0, v);
        pin[2] = 1'b1; cycles(4); pin[2] = 1'b0;
        pin[0] = 1'b1; cycles(4); pin[0] = 1'b0;
        tmr = 1'b1; cycles(1); tmr = 1'b0;
        cycles(3);

        // R8 / R4: sweep all masks and global enable
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 64; m++) begin
                int exp_irq;
                wr(2'd2, 4'(m));
                wr(2'd3, {1'(g), 1'b0, 2'(m >> 4)});
                exp_irq = (g != 0 && ((m & 6'b100101) != 0)) ? 1 : 0;
                check("R8 irq gating", int'(irq), exp_irq);
            end
        end
        peek(2'd3, v);
        check("R5 ctrl readback", int'(v), 4'b1011);
        peek(2'd2, v);
        check("R5 mask readback", int'(v), 4'hF);
        peek(2'd0, v);
        check("R4 ext flags after writes", int'(v), 4'b0101);
        peek(2'd1, v);
        check("R4 int flags after writes", int'(v), 2);

        // R10 / R11: standby and wake
        rd(2'd0, v);
        rd(2'd1, v);
        wr(2'd2, 4'h0);
        wr(2'd3, 4'b1000);
        halt = 1'b1; cycles(1); halt = 1'b0;
        check("R10 standby entered", int'(standby), 1);
        check("R11 no wake", int'(wake), 0);
        tmr = 1'b1; cycles(1); tmr = 1'b0;
        cycles(3);
        check("R11 masked flag no wake", int'(standby), 1);
        check("R11 masked irq low", int'(irq), 0);
        wr(2'd3, 4'b1010);
        check("R11 wake pulse", int'(wake), 1);
        check("R11 still standby", int'(standby), 1);
        cycles(1);
        check("R11 back to run", int'(standby), 0);
        check("R11 wake ends", int'(wake), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule